// File: doc/BRIEF.md
# Interrupt Recognition and Vector Unit

This unit sits next to a small processor sequencer and decides when an interrupt sequence begins and which vector address the sequencer should fetch. It watches two active-low request lines. The maskable line is level sensitive and gated by the interrupt-disable flag. The non-maskable line is edge sensitive: a falling edge is caught and held in a sticky pending flag until the sequencer acknowledges it.

A request is normally taken only on the instruction-boundary strobe. After the sequencer signals entry into the wait-for-interrupt condition, the unit holds a wait state. It leaves that state on its own as soon as a request appears, and raises a wake pulse as it does. On a take, the unit emits a one-cycle pulse together with an interrupt kind code and a 24-bit vector address chosen from the current operating mode. The kind and the vector stay frozen until the sequencer acknowledges.

The controller has three states:
- `S_IDLE`: running, waiting for a boundary.
- `S_WAIT`: halted in wait-for-interrupt.
- `S_HOLD`: an interrupt has been taken and the unit is waiting for the acknowledge.

It has five transitions:
- `IDLE→HOLD`: boundary with a request.
- `IDLE→WAIT`: wait entry.
- `WAIT→HOLD`: an unmasked request or a pending non-maskable request.
- `WAIT→IDLE`: wake on a masked maskable request.
- `HOLD→IDLE`: acknowledge.

Top module: `irq_vector_unit`

## Requirements
- R1: After reset, take_o, wake_o and kind_o are 0, and no non-maskable request is pending. Reset treats both request lines as previously high.
- R2: Outside the wait state, a take happens only in the cycle after a boundary_i strobe. A request held without a boundary produces no take. A boundary while a taken interrupt awaits acknowledge is ignored.
- R3: A low maskable line (irq_n_i) causes a take of kind 2'b01 only if irq_mask_i is 0 at the boundary. If the line rises before the boundary, nothing is taken. If the line is still low after acknowledge, the next boundary takes it again.
- R4: A high-to-low transition of nmi_n_i sets a pending flag. The flag survives until a take of kind 2'b10 is acknowledged. A line that stays low causes no further take. A fresh falling edge after acknowledge causes another take.
- R5: When both requests are present at a boundary, the non-maskable one (kind 2'b10) is taken first. The maskable request is taken at a later boundary if its line is still low.
- R6: take_o is high for exactly one cycle. kind_o and vec_o stay unchanged from that cycle until ack_i. After acknowledge, kind_o returns to 2'b00.
- R7: The vector depends on mode_i, where 0 is 8-bit emulation, 1 is 16-bit emulation and 2 or 3 is native:
  - Maskable: 0x00FFFE in modes 0 and 1, and 0x00FFEE in native.
  - Non-maskable: 0x00FFFA in mode 0, 0x00FFEA in mode 1, and 0x00FFDA in native.
- R8: A wai_enter_i pulse puts the unit in the wait state. There, a pending non-maskable request or an unmasked maskable request causes a take without any boundary, with wake_o high in the same cycle. A masked maskable request raises wake_o with no take and returns the unit to boundary-driven operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_n_i | input | 1 | Maskable request, active low, level |
| nmi_n_i | input | 1 | Non-maskable request, active low, falling edge |
| irq_mask_i | input | 1 | Interrupt-disable flag, 1 blocks the maskable request |
| mode_i | input | 2 | Operating mode: 0 emu8, 1 emu16, 2/3 native |
| boundary_i | input | 1 | Current instruction has completed |
| wai_enter_i | input | 1 | Sequencer enters wait-for-interrupt |
| ack_i | input | 1 | Sequencer has consumed the taken interrupt |
| take_o | output | 1 | One-cycle pulse: start interrupt sequence |
| kind_o | output | 2 | 00 none, 01 maskable, 10 non-maskable |
| vec_o | output | 24 | Vector address (low byte address) |
| wake_o | output | 1 | One-cycle pulse: leaving the wait state |

## Verification
The hardest situation to reach from the ports is the masked wake. In it, the unit must leave the wait state without taking anything, and that is visible only through what it does afterwards. The bench enters the wait state with the mask set and drops the maskable line, then watches for wake_o with no take_o. It then clears the mask and waits several cycles without a boundary to confirm no take occurs, which shows the wait state was left. Only then does it apply a boundary and expect the take. A second hard case is the non-maskable edge that arrives after an acknowledge. The bench reaches it by releasing and lowering the line again between the acknowledge and the next boundary.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;

    typedef enum logic [1:0] {
        K_NONE = 2'b00,
        K_MASK = 2'b01,
        K_NMI  = 2'b10
    } kind_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'b00,
        S_WAIT = 2'b01,
        S_HOLD = 2'b10
    } state_e;

    localparam logic [1:0] MODE_EMU8  = 2'd0;
    localparam logic [1:0] MODE_EMU16 = 2'd1;

    localparam logic [15:0] VEC_MASK_EMU = 16'hFFFE;
    localparam logic [15:0] VEC_MASK_NAT = 16'hFFEE;
    localparam logic [15:0] VEC_NMI_E8   = 16'hFFFA;
    localparam logic [15:0] VEC_NMI_E16  = 16'hFFEA;
    localparam logic [15:0] VEC_NMI_NAT  = 16'hFFDA;

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] sh_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh_q <= 1'b1;
                else        sh_q <= d_i;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh_q <= '1;
                else        sh_q <= {sh_q[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/irq_nmi_latch.sv
module irq_nmi_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic line_s_i,
    input  logic clr_i,
    output logic pend_o
);
    logic prev_q;
    logic pend_q;
    logic fall;

    assign fall = prev_q & ~line_s_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b1;
            pend_q <= 1'b0;
        end else begin
            prev_q <= line_s_i;
            if (fall)       pend_q <= 1'b1;
            else if (clr_i) pend_q <= 1'b0;
        end
    end

    assign pend_o = pend_q;

    p_pend_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !clr_i) |=> pend_q);

    p_pend_from_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_q) |-> $past(prev_q && !line_s_i));
endmodule

// File: rtl/irq_vec_sel.sv
module irq_vec_sel
    import irq_vec_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  kind_e             kind_i,
    input  logic [1:0]        mode_i,
    output logic [ADDR_W-1:0] vec_o
);
    logic [15:0] lo16;
    logic        native;

    assign native = mode_i[1];

    always_comb begin
        lo16 = VEC_MASK_EMU;
        unique case (kind_i)
            K_NMI: begin
                if (native)                  lo16 = VEC_NMI_NAT;
                else if (mode_i == MODE_EMU16) lo16 = VEC_NMI_E16;
                else                         lo16 = VEC_NMI_E8;
            end
            default: lo16 = native ? VEC_MASK_NAT : VEC_MASK_EMU;
        endcase
    end

    assign vec_o = ADDR_W'(lo16);
endmodule

// File: rtl/irq_arb_fsm.sv
module irq_arb_fsm
    import irq_vec_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boundary_i,
    input  logic              wai_enter_i,
    input  logic              ack_i,
    input  logic              nmi_pend_i,
    input  logic              irq_low_i,
    input  logic              mask_i,
    input  logic [ADDR_W-1:0] vec_i,
    output kind_e             pick_o,
    output logic              nmi_clr_o,
    output logic              take_o,
    output logic              wake_o,
    output kind_e             kind_o,
    output logic [ADDR_W-1:0] vec_o
);
    state_e st_q, st_d;
    logic   fire, wake_d, want_irq, any_req;
    kind_e  kind_q;
    logic   take_q, wake_q;
    logic [ADDR_W-1:0] vec_q;

    assign want_irq = irq_low_i & ~mask_i;
    assign any_req  = nmi_pend_i | want_irq;
    assign pick_o   = nmi_pend_i ? K_NMI : K_MASK;

    always_comb begin
        st_d   = st_q;
        fire   = 1'b0;
        wake_d = 1'b0;
        unique case (st_q)
            S_IDLE: begin
                if (boundary_i && any_req) begin
                    st_d = S_HOLD;
                    fire = 1'b1;
                end else if (wai_enter_i) begin
                    st_d = S_WAIT;
                end
            end
            S_WAIT: begin
                if (any_req) begin
                    st_d   = S_HOLD;
                    fire   = 1'b1;
                    wake_d = 1'b1;
                end else if (irq_low_i) begin
                    st_d   = S_IDLE;
                    wake_d = 1'b1;
                end
            end
            S_HOLD: begin
                if (ack_i) st_d = S_IDLE;
            end
            default: st_d = S_IDLE;
        endcase
    end

    assign nmi_clr_o = (st_q == S_HOLD) && ack_i && (kind_q == K_NMI);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            take_q <= 1'b0;
            wake_q <= 1'b0;
            kind_q <= K_NONE;
            vec_q  <= '0;
        end else begin
            take_q <= fire;
            wake_q <= wake_d;
            if (fire) begin
                kind_q <= pick_o;
                vec_q  <= vec_i;
            end else if (st_q == S_HOLD && ack_i) begin
                kind_q <= K_NONE;
            end
        end
    end

    assign take_o = take_q;
    assign wake_o = wake_q;
    assign kind_o = kind_q;
    assign vec_o  = vec_q;

    p_take_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        take_q |=> !take_q);

    p_hold_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_HOLD && !ack_i) |=> ($stable(kind_q) && $stable(vec_q)));

    p_take_qualified_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(take_q) |-> ($past(boundary_i) || $past(st_q == S_WAIT)));

    p_wake_from_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wake_q |-> $past(st_q == S_WAIT));

    p_kind_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(kind_q));

    p_nmi_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && nmi_pend_i) |=> (kind_q == K_NMI));
endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit
    import irq_vec_pkg::*;
#(
    parameter int ADDR_W      = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_n_i,
    input  logic              nmi_n_i,
    input  logic              irq_mask_i,
    input  logic [1:0]        mode_i,
    input  logic              boundary_i,
    input  logic              wai_enter_i,
    input  logic              ack_i,
    output logic              take_o,
    output logic [1:0]        kind_o,
    output logic [ADDR_W-1:0] vec_o,
    output logic              wake_o
);
    logic irq_s, nmi_s, nmi_pend, nmi_clr;
    kind_e pick, kind;
    logic [ADDR_W-1:0] vec_pick;

    irq_sync #(.STAGES(SYNC_STAGES)) u_sync_irq (
        .clk(clk), .rst_n(rst_n), .d_i(irq_n_i), .q_o(irq_s));

    irq_sync #(.STAGES(SYNC_STAGES)) u_sync_nmi (
        .clk(clk), .rst_n(rst_n), .d_i(nmi_n_i), .q_o(nmi_s));

    irq_nmi_latch u_nmi (
        .clk(clk), .rst_n(rst_n), .line_s_i(nmi_s),
        .clr_i(nmi_clr), .pend_o(nmi_pend));

    irq_vec_sel #(.ADDR_W(ADDR_W)) u_vec (
        .kind_i(pick), .mode_i(mode_i), .vec_o(vec_pick));

    irq_arb_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .boundary_i(boundary_i), .wai_enter_i(wai_enter_i), .ack_i(ack_i),
        .nmi_pend_i(nmi_pend), .irq_low_i(~irq_s), .mask_i(irq_mask_i),
        .vec_i(vec_pick), .pick_o(pick), .nmi_clr_o(nmi_clr),
        .take_o(take_o), .wake_o(wake_o), .kind_o(kind), .vec_o(vec_o));

    assign kind_o = kind;
endmodule

// File: tb/irq_vector_unit_tb_top.sv
`timescale 1ns/1ps
module irq_vector_unit_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic irq_n = 1'b1, nmi_n = 1'b1, mask = 1'b0;
    logic [1:0] mode = 2'd0;
    logic bnd = 1'b0, wai = 1'b0, ack = 1'b0;
    logic take, wake;
    logic [1:0] kind;
    logic [23:0] vec;
    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    irq_vector_unit dut_i (
        .clk(clk), .rst_n(rst_n), .irq_n_i(irq_n), .nmi_n_i(nmi_n),
        .irq_mask_i(mask), .mode_i(mode), .boundary_i(bnd),
        .wai_enter_i(wai), .ack_i(ack), .take_o(take), .kind_o(kind),
        .vec_o(vec), .wake_o(wake));

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] exp_vec(bit nmi, int m);
        int nat = (m >= 2) ? 1 : 0;
        if (nmi) return 24'h00FFFA - 24'(16 * (nat ? 2 : m));
        return 24'h00FFFE - 24'(16 * nat);
    endfunction

    task automatic cyc(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic boundary();
        bnd = 1'b1;
        @(negedge clk);
        bnd = 1'b0;
    endtask

    task automatic do_ack();
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
    endtask

    task automatic enter_wait();
        wai = 1'b1;
        @(negedge clk);
        wai = 1'b0;
    endtask

    task automatic poll(int lim, output bit st, output bit sw, output logic [1:0] k);
        st = 0; sw = 0; k = 2'b00;
        for (int i = 0; i < lim; i++) begin
            @(negedge clk);
            if (take) begin st = 1; k = kind; end
            if (wake) sw = 1;
            if (take || wake) break;
        end
    endtask

    initial begin
        bit st, sw;
        logic [1:0] k;
        logic [23:0] v0;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        chk("R1 take", take, 0);
        chk("R1 wake", wake, 0);
        chk("R1 kind", kind, 0);
        boundary();
        chk("R1 no pending nmi after reset", take, 0);

        for (int m = 0; m < 4; m++) begin
            mode = 2'(m);
            irq_n = 1'b0;
            cyc(4);
            chk("R2 no take without boundary", take, 0);
            boundary();
            chk("R3 take irq", take, 1);
            chk("R3 kind irq", kind, 2'b01);
            chk("R7 irq vector", vec, exp_vec(0, m));
            v0 = vec;
            boundary();
            chk("R6 take single / R2 boundary in hold ignored", take, 0);
            chk("R6 vec stable", vec, v0);
            chk("R6 kind stable", kind, 2'b01);
            irq_n = 1'b1;
            do_ack();
            chk("R6 kind cleared on ack", kind, 0);
            cyc(3);
            nmi_n = 1'b0;
            cyc(5);
            boundary();
            chk("R4 take nmi", take, 1);
            chk("R4 kind nmi", kind, 2'b10);
            chk("R7 nmi vector", vec, exp_vec(1, m));
            cyc(1);
            do_ack();
            cyc(2);
            boundary();
            chk("R4 held low no retrigger", take, 0);
            nmi_n = 1'b1;
            cyc(4);
        end

        mode = 2'd0;
        mask = 1'b1; irq_n = 1'b0;
        cyc(4);
        boundary();
        chk("R3 masked no take", take, 0);
        mask = 1'b0;
        boundary();
        chk("R3 unmasked take", take, 1);
        do_ack();
        boundary();
        chk("R3 still low retakes", take, 1);
        chk("R3 retake kind", kind, 2'b01);
        irq_n = 1'b1;
        do_ack();
        cyc(4);
        boundary();
        chk("R3 released no take", take, 0);
        irq_n = 1'b0; cyc(4); irq_n = 1'b1; cyc(4);
        boundary();
        chk("R3 withdrawn before boundary", take, 0);

        irq_n = 1'b0; nmi_n = 1'b0;
        cyc(5);
        boundary();
        chk("R5 nmi wins", kind, 2'b10);
        do_ack();
        boundary();
        chk("R5 irq kept", take, 1);
        chk("R5 irq kind", kind, 2'b01);
        irq_n = 1'b1;
        do_ack();
        nmi_n = 1'b1;
        cyc(4);

        nmi_n = 1'b0; cyc(5);
        boundary();
        do_ack();
        nmi_n = 1'b1; cyc(3); nmi_n = 1'b0; cyc(5);
        boundary();
        chk("R4 new edge after ack", take, 1);
        chk("R4 new edge kind", kind, 2'b10);
        do_ack();
        nmi_n = 1'b1; cyc(4);

        enter_wait();
        cyc(5);
        chk("R8 idle wait no take", take, 0);
        chk("R8 idle wait no wake", wake, 0);
        mode = 2'd2;
        nmi_n = 1'b0;
        poll(12, st, sw, k);
        chk("R8 nmi take in wait", st, 1);
        chk("R8 wake with take", sw, 1);
        chk("R8 kind", k, 2'b10);
        chk("R7 native nmi vec", vec, exp_vec(1, 2));
        do_ack();
        nmi_n = 1'b1; cyc(4);

        enter_wait();
        irq_n = 1'b0;
        poll(12, st, sw, k);
        chk("R8 irq take in wait", st, 1);
        chk("R8 irq wake", sw, 1);
        chk("R8 irq kind", k, 2'b01);
        irq_n = 1'b1;
        do_ack();
        cyc(4);

        mask = 1'b1;
        enter_wait();
        irq_n = 1'b0;
        poll(12, st, sw, k);
        chk("R8 masked wake", sw, 1);
        chk("R8 masked no take", st, 0);
        mask = 1'b0;
        cyc(4);
        chk("R8 left wait: no take without boundary", take, 0);
        boundary();
        chk("R8 boundary after masked wake", take, 1);
        irq_n = 1'b1;
        do_ack();
        cyc(3);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule